// File: doc/BRIEF.md
# Instruction-Stepped Divider and Programmable Timer

This block keeps time for a processor model that advances in whole instructions, not single clocks. On each step the core reports how many CPU clock cycles the last instruction took (CPU clock 4194304 Hz). The block adds that amount into two accumulators. One drives a divider register that never stops and counts at 16384 Hz. The other drives a programmable 8-bit counter. That counter runs at one of four rates, reloads from a modulo register when it passes 0xFF, and raises a timer interrupt request.

Software reaches the four registers through a plain byte-wide port at addresses 0xFF04 to 0xFF07. Reads are combinational from the address. Writes take effect at the clock edge. A step can be larger than the counter period, so one step may hold several counter increments, reloads and overflows. The block applies all of them within that single step and reports the number of overflows alongside a one-cycle interrupt request.

Top module: `step_timer`

## Requirements
- R1: After reset, every register reads 0 (timer stopped, rate code 00), `tmr_irq` is 0 and `tmr_ovf_cnt` is 0.
- R2: Each valid step adds `step_cycles` into an 8-bit divider accumulator. A carry out of bit 7 adds 1 to the divider register at 0xFF04, and the wrapped remainder is kept. For example, 250 followed by 12 gives one increment and leaves 6 toward the next.
- R3: A write to 0xFF04 clears both the divider register and its accumulator, whatever the data. In that cycle the step is ignored by the divider only.
- R4: 0xFF05 is the counter, 0xFF06 the modulo and 0xFF07 the control register, all readable and writable. Control keeps bits 2:0 only, and bits 7:3 read 0. Any other address reads 0.
- R5: Control bit 2 = 1 runs the timer. While it is 0, steps change neither the counter nor the timer accumulator.
- R6: The timer uses its own accumulator. Control bits 1:0 choose the CPU-cycle period of one counter increment: 00 → 1024, 01 → 16, 10 → 64, 11 → 256.
- R7: An increment from 0xFF loads the modulo value instead of 0. In the cycle after the step, `tmr_irq` is 1 for exactly one cycle and `tmr_ovf_cnt` gives the number of such overflows. With no overflow, both are 0.
- R8: A single step that spans several counter periods applies every increment, reload and overflow in that step, including a modulo of 0xFF, where every increment overflows.
- R9: A write to the counter in the same cycle as a step sets the counter to the written value, overriding any increment or reload. The overflows of that step are still reported.
- R10: A write to control clears the timer accumulator. A step in the same cycle uses the old control value.
- R11: A write to the modulo register in the same cycle as a step takes effect after it; reloads in that step use the old modulo value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | One instruction step is reported this cycle |
| step_cycles | input | CYC_W (8) | CPU cycles taken by that instruction |
| bus_addr | input | 16 | Register address (read and write) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| tmr_irq | output | 1 | Timer interrupt request, one cycle |
| tmr_ovf_cnt | output | OVF_W (5) | Counter overflows in the last step |

## Verification
The assertions check these rules on every cycle:
- the divider moves by at most one per step and returns to zero after a write;
- a stopped timer holds its counter;
- a counter write wins;
- a control write empties the timer accumulator;
- the accumulator stays below the selected period;
- overflows appear only after a step of a running timer.

The exact count of increments, reloads and overflows for each rate, modulo and step size can only be shown by the bench's sweeps. The same holds for same-cycle cases where a write lands with a step (old control, old modulo) and for remainder carry-over across steps.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int REG_W = 8;
    localparam logic [15:0] ADDR_DIV = 16'hFF04;
    localparam logic [15:0] ADDR_CNT = 16'hFF05;
    localparam logic [15:0] ADDR_MOD = 16'hFF06;
    localparam logic [15:0] ADDR_CTL = 16'hFF07;
    localparam int CTL_W = 3;
    localparam int CTL_RUN = 2;
    // shortest and longest counter period, as powers of two
    localparam int MIN_SH = 4;
    localparam int MAX_SH = 10;

    typedef struct packed {
        logic wr_div;
        logic wr_cnt;
        logic wr_mod;
        logic wr_ctl;
    } wr_strb_t;

    // rate code -> log2 of CPU cycles per counter increment
    function automatic int rate_shift(input logic [1:0] code);
        case (code)
            2'b00: return 10;
            2'b01: return 4;
            2'b10: return 6;
            default: return 8;
        endcase
    endfunction
endpackage

// File: rtl/tmr_bus_dec.sv
module tmr_bus_dec
    import tmr_pkg::*;
(
    input  logic [15:0]      bus_addr,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] div_val,
    input  logic [REG_W-1:0] cnt_val,
    input  logic [REG_W-1:0] mod_val,
    input  logic [CTL_W-1:0] ctl_val,
    output wr_strb_t         strb,
    output logic [REG_W-1:0] rdata
);
    always_comb begin
        strb        = '0;
        strb.wr_div = bus_wr && (bus_addr == ADDR_DIV);
        strb.wr_cnt = bus_wr && (bus_addr == ADDR_CNT);
        strb.wr_mod = bus_wr && (bus_addr == ADDR_MOD);
        strb.wr_ctl = bus_wr && (bus_addr == ADDR_CTL);
        case (bus_addr)
            ADDR_DIV: rdata = div_val;
            ADDR_CNT: rdata = cnt_val;
            ADDR_MOD: rdata = mod_val;
            ADDR_CTL: rdata = {{(REG_W-CTL_W){1'b0}}, ctl_val};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_div_unit.sv
module tmr_div_unit
    import tmr_pkg::*;
#(
    parameter int CYC_W     = 8,
    parameter int DIV_ACC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_valid,
    input  logic [CYC_W-1:0] step_cycles,
    input  logic             clr,
    output logic [REG_W-1:0] div_val
);
    localparam int SUM_W = DIV_ACC_W + 1;

    typedef struct packed {
        logic [DIV_ACC_W-1:0] acc;
        logic [REG_W-1:0]     div;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = SUM_W'(st_q.acc) + SUM_W'(step_cycles);
        if (clr) begin
            st_d.acc = '0;
            st_d.div = '0;
        end else if (step_valid) begin
            st_d.acc = sum[DIV_ACC_W-1:0];
            st_d.div = st_q.div + REG_W'(sum[DIV_ACC_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign div_val = st_q.div;

    // R3
    div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (div_val == '0));

    // R2
    div_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((div_val == $past(div_val)) || (div_val == $past(div_val) + 8'd1)));
endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit
    import tmr_pkg::*;
#(
    parameter int CYC_W     = 8,
    parameter int TACC_W    = MAX_SH,
    parameter int MAX_TICKS = 16,
    parameter int OVF_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_valid,
    input  logic [CYC_W-1:0] step_cycles,
    input  wr_strb_t         strb,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cnt_val,
    output logic [REG_W-1:0] mod_val,
    output logic [CTL_W-1:0] ctl_val,
    output logic [OVF_W-1:0] ovf_cnt
);
    localparam int SUM_W = TACC_W + 1;

    typedef struct packed {
        logic [TACC_W-1:0] acc;
        logic [REG_W-1:0]  cnt;
        logic [REG_W-1:0]  mod;
        logic [CTL_W-1:0]  ctl;
        logic [OVF_W-1:0]  ovf;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    logic [SUM_W-1:0] sum, mask, ticks, lim;
    logic [REG_W-1:0] walk;
    logic [OVF_W-1:0] ovf_n;
    logic             run;

    always_comb begin
        run   = st_q.ctl[CTL_RUN];
        lim   = SUM_W'(1) << rate_shift(st_q.ctl[1:0]);
        mask  = lim - SUM_W'(1);
        sum   = SUM_W'(st_q.acc) + SUM_W'(step_cycles);
        ticks = sum >> rate_shift(st_q.ctl[1:0]);
        walk  = st_q.cnt;
        ovf_n = '0;
        for (int i = 0; i < MAX_TICKS; i++) begin
            if (SUM_W'(i) < ticks) begin
                if (walk == {REG_W{1'b1}}) begin
                    walk  = st_q.mod;
                    ovf_n = ovf_n + OVF_W'(1);
                end else begin
                    walk = walk + REG_W'(1);
                end
            end
        end

        st_d     = st_q;
        st_d.ovf = '0;
        if (run && step_valid) begin
            st_d.acc = TACC_W'(sum & mask);
            st_d.cnt = walk;
            st_d.ovf = ovf_n;
        end
        if (strb.wr_cnt) st_d.cnt = wdata;
        if (strb.wr_mod) st_d.mod = wdata;
        if (strb.wr_ctl) begin
            st_d.ctl = wdata[CTL_W-1:0];
            st_d.acc = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_val = st_q.cnt;
    assign mod_val = st_q.mod;
    assign ctl_val = st_q.ctl;
    assign ovf_cnt = st_q.ovf;

    // R5
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !strb.wr_cnt) |=> $stable(cnt_val));

    // R9
    cnt_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strb.wr_cnt |=> (cnt_val == $past(wdata)));

    // R10
    ctl_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strb.wr_ctl |=> (st_q.acc == '0));

    // R6
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        SUM_W'(st_q.acc) < lim);

    // R7
    ovf_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_cnt != '0) |-> $past(run && step_valid));
endmodule

// File: rtl/step_timer.sv
module step_timer
    import tmr_pkg::*;
#(
    parameter int CYC_W     = 8,
    parameter int DIV_ACC_W = 8,
    parameter int MAX_TICKS = ((2 ** CYC_W) - 1 + (2 ** MIN_SH) - 1) / (2 ** MIN_SH),
    parameter int OVF_W     = $clog2(MAX_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_valid,
    input  logic [CYC_W-1:0] step_cycles,
    input  logic [15:0]      bus_addr,
    input  logic             bus_wr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             tmr_irq,
    output logic [OVF_W-1:0] tmr_ovf_cnt
);
    wr_strb_t         strb;
    logic [REG_W-1:0] div_val, cnt_val, mod_val;
    logic [CTL_W-1:0] ctl_val;

    tmr_bus_dec u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .div_val  (div_val),
        .cnt_val  (cnt_val),
        .mod_val  (mod_val),
        .ctl_val  (ctl_val),
        .strb     (strb),
        .rdata    (bus_rdata)
    );

    tmr_div_unit #(.CYC_W(CYC_W), .DIV_ACC_W(DIV_ACC_W)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_valid  (step_valid),
        .step_cycles (step_cycles),
        .clr         (strb.wr_div),
        .div_val     (div_val)
    );

    tmr_count_unit #(
        .CYC_W(CYC_W), .TACC_W(MAX_SH), .MAX_TICKS(MAX_TICKS), .OVF_W(OVF_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_valid  (step_valid),
        .step_cycles (step_cycles),
        .strb        (strb),
        .wdata       (bus_wdata),
        .cnt_val     (cnt_val),
        .mod_val     (mod_val),
        .ctl_val     (ctl_val),
        .ovf_cnt     (tmr_ovf_cnt)
    );

    assign tmr_irq = (tmr_ovf_cnt != '0);
endmodule

// File: tb/sim_step_timer.sv
`timescale 1ns/1ps
module sim_step_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_valid = 1'b0;
    logic [7:0]  step_cycles = '0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        tmr_irq;
    logic [4:0]  tmr_ovf_cnt;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench model state
    int m_div, m_dacc, m_cnt, m_mod, m_ctl, m_tacc, m_ovf;

    always #10 clk = ~clk;

    step_timer u0 (
        .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_cycles(step_cycles),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tmr_irq(tmr_irq), .tmr_ovf_cnt(tmr_ovf_cnt)
    );

    function automatic int period(input int code);
        case (code & 3)
            0: return 1024;
            1: return 16;
            2: return 64;
            default: return 256;
        endcase
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected-value update for one clock with the given stimulus
    task automatic model(input bit v, input int cyc, input bit wr, input int addr, input int data);
        int s, tk;
        m_ovf = 0;
        if (wr && addr == 'hFF04) begin
            m_div = 0; m_dacc = 0;
        end else if (v) begin
            s = m_dacc + cyc;
            if (s >= 256) m_div = (m_div + 1) % 256;
            m_dacc = s % 256;
        end
        if (v && (m_ctl & 4) != 0) begin
            s = m_tacc + cyc;
            tk = s / period(m_ctl);
            m_tacc = s % period(m_ctl);
            for (int i = 0; i < tk; i++) begin
                if (m_cnt == 255) begin m_cnt = m_mod; m_ovf++; end
                else m_cnt++;
            end
        end
        if (wr && addr == 'hFF05) m_cnt = data & 255;
        if (wr && addr == 'hFF06) m_mod = data & 255;
        if (wr && addr == 'hFF07) begin m_ctl = data & 7; m_tacc = 0; end
    endtask

    task automatic cyc1(input bit v, input int cyc, input bit wr, input int addr, input int data);
        @(negedge clk);
        step_valid  = v;
        step_cycles = 8'(cyc);
        bus_wr      = wr;
        bus_addr    = 16'(addr);
        bus_wdata   = 8'(data);
        @(posedge clk);
        #1;
        step_valid = 1'b0;
        bus_wr     = 1'b0;
        model(v, cyc, wr, addr, data);
    endtask

    task automatic rd(input int addr, output int val);
        bus_addr = 16'(addr);
        #1;
        val = int'(bus_rdata);
    endtask

    task automatic chk_irq(input string tag);
        chk(int'(tmr_ovf_cnt), m_ovf, tag);
        chk(int'(tmr_irq), (m_ovf != 0) ? 1 : 0, tag);
    endtask

    task automatic chk_regs(input string tag);
        int r;
        rd('hFF04, r); chk(r, m_div, {tag, " div"});
        rd('hFF05, r); chk(r, m_cnt, {tag, " cnt"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int r;
        m_div = 0; m_dacc = 0; m_cnt = 0; m_mod = 0; m_ctl = 0; m_tacc = 0; m_ovf = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int a = 'hFF04; a <= 'hFF07; a++) begin
            rd(a, r); chk(r, 0, "R1 reg after reset");
        end
        chk(int'(tmr_irq), 0, "R1 irq");
        chk(int'(tmr_ovf_cnt), 0, "R1 ovf");

        // R2: 250 then 12 -> one increment, remainder kept
        cyc1(1, 250, 0, 0, 0); rd('hFF04, r); chk(r, 0, "R2 div after 250");
        cyc1(1, 12, 0, 0, 0);  rd('hFF04, r); chk(r, 1, "R2 div after +12");
        cyc1(1, 249, 0, 0, 0); rd('hFF04, r); chk(r, 1, "R2 remainder 6+249");
        cyc1(1, 1, 0, 0, 0);   rd('hFF04, r); chk(r, 2, "R2 remainder carry");
        for (int k = 0; k < 40; k++) begin
            cyc1(1, (k * 91 + 7) % 256, 0, 0, 0);
            rd('hFF04, r); chk(r, m_div, "R2 divider sweep");
        end

        // R3: divider write clears divider and accumulator, any data
        cyc1(1, 200, 0, 0, 0);
        cyc1(1, 100, 1, 'hFF04, 'hA5);
        rd('hFF04, r); chk(r, 0, "R3 div cleared");
        cyc1(1, 255, 0, 0, 0);
        rd('hFF04, r); chk(r, 0, "R3 accumulator cleared");

        // R4: register map
        cyc1(0, 0, 1, 'hFF06, 'h5A); rd('hFF06, r); chk(r, 'h5A, "R4 modulo rw");
        cyc1(0, 0, 1, 'hFF05, 'hC3); rd('hFF05, r); chk(r, 'hC3, "R4 counter rw");
        cyc1(0, 0, 1, 'hFF07, 'hFB); rd('hFF07, r); chk(r, 'h03, "R4 control bits 7:3 read 0");
        rd('hFF08, r); chk(r, 0, "R4 unmapped high");
        rd('hFF03, r); chk(r, 0, "R4 unmapped low");

        // R5: stopped timer ignores steps
        for (int k = 0; k < 8; k++) begin
            cyc1(1, 255, 0, 0, 0);
            rd('hFF05, r); chk(r, 'hC3, "R5 stopped counter");
            chk_irq("R5 stopped irq");
        end

        // R6/R7/R8: sweep rates, modulos and step sizes
        for (int rate = 0; rate < 4; rate++) begin
            for (int mi = 0; mi < 4; mi++) begin
                int mv;
                mv = (mi == 0) ? 'h00 : (mi == 1) ? 'hF0 : (mi == 2) ? 'hFE : 'hFF;
                cyc1(0, 0, 1, 'hFF06, mv);
                cyc1(0, 0, 1, 'hFF05, 'hF8);
                cyc1(0, 0, 1, 'hFF07, 4 | rate);
                for (int k = 0; k < 40; k++) begin
                    cyc1(1, (k * 37 + 13) % 256, 0, 0, 0);
                    chk_irq(rate == 1 ? "R8 multi-overflow count" : "R7 overflow irq");
                    rd('hFF05, r);
                    chk(r, m_cnt, rate == 1 ? "R8 multi-tick counter" : "R6 rate counter");
                end
                chk_regs("R6 sweep end");
            end
        end

        // R9: counter write wins over a same-step overflow
        cyc1(0, 0, 1, 'hFF07, 'h05);
        cyc1(0, 0, 1, 'hFF06, 'h33);
        cyc1(0, 0, 1, 'hFF05, 'hFF);
        cyc1(1, 16, 1, 'hFF05, 'h77);
        rd('hFF05, r); chk(r, 'h77, "R9 counter write priority");
        chk(int'(tmr_ovf_cnt), 1, "R9 overflow still reported");

        // R11: modulo write during overflow step uses old modulo
        cyc1(0, 0, 1, 'hFF05, 'hFF);
        cyc1(1, 16, 1, 'hFF06, 'h99);
        rd('hFF05, r); chk(r, 'h33, "R11 reload uses old modulo");
        rd('hFF06, r); chk(r, 'h99, "R11 modulo updated");
        chk_irq("R11 irq");

        // R10: control write uses old rate this step, then clears accumulator
        cyc1(0, 0, 1, 'hFF07, 'h07);
        cyc1(0, 0, 1, 'hFF05, 'h10);
        cyc1(1, 200, 0, 0, 0);
        rd('hFF05, r); chk(r, 'h10, "R10 partial period");
        cyc1(1, 100, 1, 'hFF07, 'h04);
        rd('hFF05, r); chk(r, 'h11, "R10 old rate applied");
        for (int k = 0; k < 4; k++) begin
            cyc1(1, 255, 0, 0, 0);
            rd('hFF05, r); chk(r, 'h11, "R10 accumulator cleared");
        end
        cyc1(1, 4, 0, 0, 0);
        rd('hFF05, r); chk(r, 'h12, "R10 new period reached");
        chk_regs("R10 end");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule